// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It runs two predictors side by side. The local predictor selects a per-branch history register using PC bits. That history then indexes a table of 3-bit saturating counters. The global predictor uses one shared history of recent outcomes to index a table of 2-bit counters. A third table of 2-bit chooser counters, indexed by the same global history, selects which of the two answers is given.

A fetch stage presents a PC on the predict port and receives the direction one cycle later. With the direction it receives the local-counter index and the global index that were used. When the branch resolves, the caller returns the PC, the actual outcome and those two indices on the update port. The counters are then trained at the indices that made the prediction, even if the histories have moved in the meantime. Updates shift the histories. Target prediction and history repair after a misprediction are not part of this block.

Top module: `tourney_pred`

## Requirements
- R1: After reset every local counter holds 3, every global and chooser counter holds 1, and every history is zero, so the first prediction is not taken and carries local index 0 and global index 0.
- R2: A prediction request in one cycle gives `pred_valid` high in the next cycle, with the result of that request. A cycle with no request gives `pred_valid` low in the next cycle.
- R3: Each update shifts the 12-bit global history left by one bit and places the actual outcome in bit 0. `pred_gidx` shows the global history that was current when the request was made.
- R4: The local history row is selected by PC bits [11:2]. Each update shifts only that row, with the outcome entering bit 0. `pred_lidx` shows the row's history at request time.
- R5: Local counters are 3-bit and saturate at 0 and 7. Each one votes taken when its value is 4 or more.
- R6: Global counters are 2-bit and saturate at 0 and 3. Each one votes taken when its value is 2 or more.
- R7: The prediction follows the global vote when the chooser counter at the global index is 2 or more, and the local vote otherwise. On update the chooser changes only when exactly one vote was correct: it counts up when the global vote was correct and down when the local vote was correct, saturating at 0 and 3.
- R8: On update, the local and global counters are trained toward the outcome at the supplied `upd_lidx` and `upd_gidx`, not at the current histories. The chooser is trained at `upd_gidx`, using the votes held at those indices before the update.
- R9: A prediction made in the same cycle as an update reads the state from before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_req | input | 1 | Prediction request |
| pred_pc | input | 32 | PC of the branch to predict |
| pred_valid | output | 1 | Prediction result valid |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_lidx | output | 10 | Local counter index used |
| pred_gidx | output | 12 | Global and chooser index used |
| upd_valid | input | 1 | Update strobe |
| upd_pc | input | 32 | PC of the resolved branch |
| upd_taken | input | 1 | Actual outcome |
| upd_lidx | input | 10 | Local index returned from prediction |
| upd_gidx | input | 12 | Global index returned from prediction |

## Verification
The bench keeps updates two cycles behind their predictions in some phases, so the histories move between prediction and training. A design that trained at the current histories instead of the returned indices would then diverge in direction. Several branches share one local history row by differing only above PC bit 11. A wrong row selection or a shift of the wrong row would show up as a wrong `pred_lidx`. Outcome patterns drive counters to both saturation limits, where a wrap would flip a strongly biased vote. Because predictions and updates overlap in the same cycle, a design that exposed post-update state would report a shifted `pred_gidx`. A chooser trained when both votes agree would pick the wrong component in later predictions.

// File: rtl/tourney_pred.sv
module tourney_pred #(
  parameter int PC_W = 32,
  parameter int RW   = 10,
  parameter int LHW  = 10,
  parameter int GHW  = 12,
  parameter int LCW  = 3,
  parameter int GCW  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pred_req,
  input  logic [PC_W-1:0] pred_pc,
  output logic            pred_valid,
  output logic            pred_taken,
  output logic [LHW-1:0]  pred_lidx,
  output logic [GHW-1:0]  pred_gidx,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken,
  input  logic [LHW-1:0]  upd_lidx,
  input  logic [GHW-1:0]  upd_gidx
);
  localparam int ROWS = 1 << RW;
  localparam int LCN  = 1 << LHW;
  localparam int GN   = 1 << GHW;
  localparam logic [LCW-1:0] LC_INIT = LCW'((1 << (LCW-1)) - 1);
  localparam logic [GCW-1:0] GC_INIT = GCW'((1 << (GCW-1)) - 1);

  logic [LHW-1:0] lhist [ROWS];
  logic [LCW-1:0] lctr  [LCN];
  logic [GCW-1:0] gctr  [GN];
  logic [GCW-1:0] chs   [GN];
  logic [GHW-1:0] ghr;

  logic [RW-1:0] prow, urow;
  assign prow = pred_pc[RW+1:2];
  assign urow = upd_pc[RW+1:2];

  logic unused_pc_bits;
  assign unused_pc_bits = ^{pred_pc[PC_W-1:RW+2], pred_pc[1:0],
                            upd_pc[PC_W-1:RW+2], upd_pc[1:0]};

  logic [LHW-1:0] plh;
  logic p_loc, p_glb, p_sel, u_loc, u_glb;
  assign plh   = lhist[prow];
  assign p_loc = lctr[plh][LCW-1];
  assign p_glb = gctr[ghr][GCW-1];
  assign p_sel = chs[ghr][GCW-1];
  assign u_loc = lctr[upd_lidx][LCW-1];
  assign u_glb = gctr[upd_gidx][GCW-1];

  logic [LCW-1:0] lc_cur, lc_nxt;
  logic [GCW-1:0] gc_cur, gc_nxt, ch_cur, ch_nxt;
  assign lc_cur = lctr[upd_lidx];
  assign gc_cur = gctr[upd_gidx];
  assign ch_cur = chs[upd_gidx];
  assign lc_nxt = upd_taken ? ((&lc_cur) ? lc_cur : lc_cur + 1'b1)
                            : ((|lc_cur) ? lc_cur - 1'b1 : lc_cur);
  assign gc_nxt = upd_taken ? ((&gc_cur) ? gc_cur : gc_cur + 1'b1)
                            : ((|gc_cur) ? gc_cur - 1'b1 : gc_cur);
  assign ch_nxt = (u_glb == upd_taken) ? ((&ch_cur) ? ch_cur : ch_cur + 1'b1)
                                       : ((|ch_cur) ? ch_cur - 1'b1 : ch_cur);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pred_valid <= 1'b0;
      pred_taken <= 1'b0;
      pred_lidx  <= '0;
      pred_gidx  <= '0;
    end else begin
      pred_valid <= pred_req;
      if (pred_req) begin
        pred_taken <= p_sel ? p_glb : p_loc;
        pred_lidx  <= plh;
        pred_gidx  <= ghr;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ghr <= '0;
      for (int i = 0; i < ROWS; i++) lhist[i] <= '0;
    end else if (upd_valid) begin
      ghr         <= {ghr[GHW-2:0], upd_taken};
      lhist[urow] <= {lhist[urow][LHW-2:0], upd_taken};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LCN; i++) lctr[i] <= LC_INIT;
    end else if (upd_valid) begin
      lctr[upd_lidx] <= lc_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < GN; i++) begin
        gctr[i] <= GC_INIT;
        chs[i]  <= GC_INIT;
      end
    end else if (upd_valid) begin
      gctr[upd_gidx] <= gc_nxt;
      if (u_loc != u_glb) chs[upd_gidx] <= ch_nxt;
    end
  end
endmodule

module tourney_pred_chk #(
  parameter int GHW = 12
) (
  input logic           clk,
  input logic           rst_n,
  input logic           pred_req,
  input logic           upd_valid,
  input logic           upd_taken,
  input logic           pred_valid,
  input logic [GHW-1:0] pred_gidx,
  input logic [GHW-1:0] ghr
);
  p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pred_req |=> pred_valid);
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !pred_req |=> !pred_valid);
  p_ghr_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> ghr == {$past(ghr[GHW-2:0]), $past(upd_taken)});
  p_ghr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> $stable(ghr));
  p_gidx_pre_update_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pred_req |=> pred_gidx == $past(ghr));
endmodule

bind tourney_pred tourney_pred_chk #(.GHW(GHW)) chk_i (
  .clk(clk), .rst_n(rst_n), .pred_req(pred_req), .upd_valid(upd_valid),
  .upd_taken(upd_taken), .pred_valid(pred_valid), .pred_gidx(pred_gidx),
  .ghr(ghr)
);

// File: tb/tourney_pred_tb.sv
module tourney_pred_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pred_req = 1'b0;
  logic [31:0] pred_pc = '0;
  logic        pred_valid, pred_taken;
  logic [9:0]  pred_lidx;
  logic [11:0] pred_gidx;
  logic        upd_valid = 1'b0;
  logic [31:0] upd_pc = '0;
  logic        upd_taken = 1'b0;
  logic [9:0]  upd_lidx = '0;
  logic [11:0] upd_gidx = '0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  tourney_pred dut_i (
    .clk(clk), .rst_n(rst_n), .pred_req(pred_req), .pred_pc(pred_pc),
    .pred_valid(pred_valid), .pred_taken(pred_taken), .pred_lidx(pred_lidx),
    .pred_gidx(pred_gidx), .upd_valid(upd_valid), .upd_pc(upd_pc),
    .upd_taken(upd_taken), .upd_lidx(upd_lidx), .upd_gidx(upd_gidx)
  );

  // behavioural reference state
  int m_lh [1024];
  int m_lc [1024];
  int m_gc [4096];
  int m_ch [4096];
  int m_ghr;
  int e_v, e_t, e_li, e_gi;

  // pending updates: pc, lidx, gidx, outcome
  int q_pc[$], q_li[$], q_gi[$], q_out[$];

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cycles);
    end
  endtask

  function automatic int satu(int c, bit up, int mx);
    if (up) return (c == mx) ? c : c + 1;
    return (c == 0) ? c : c - 1;
  endfunction

  // one clock: drive, let the edge happen, advance the model, compare at negedge
  task automatic cyc(bit pv, int ppc, bit uv, int upc, bit ut, int uli, int ugi);
    bit lv, gv;
    pred_req = pv; pred_pc = ppc;
    upd_valid = uv; upd_pc = upc; upd_taken = ut;
    upd_lidx = uli[9:0]; upd_gidx = ugi[11:0];
    @(posedge clk);
    cycles++;
    e_v = pv;
    if (pv) begin
      // R9: prediction uses state before this cycle's update
      e_li = m_lh[(ppc >> 2) & 1023];
      e_gi = m_ghr;
      e_t  = (m_ch[e_gi] >= 2) ? int'(m_gc[e_gi] >= 2) : int'(m_lc[e_li] >= 4);
    end
    if (uv) begin
      lv = (m_lc[uli] >= 4);
      gv = (m_gc[ugi] >= 2);
      if (lv != gv) m_ch[ugi] = satu(m_ch[ugi], gv == ut, 3);  // R7
      m_lc[uli] = satu(m_lc[uli], ut, 7);                       // R5 R8
      m_gc[ugi] = satu(m_gc[ugi], ut, 3);                       // R6 R8
      m_lh[(upc >> 2) & 1023] = ((m_lh[(upc >> 2) & 1023] << 1) | ut) & 1023; // R4
      m_ghr = ((m_ghr << 1) | ut) & 4095;                       // R3
    end
    @(negedge clk);
    chk("R2 pred_valid", int'(pred_valid), e_v);
    if (e_v != 0) begin
      chk("R5 R6 R7 R8 pred_taken", int'(pred_taken), e_t);
      chk("R4 R8 pred_lidx", int'(pred_lidx), e_li);
      chk("R3 R9 pred_gidx", int'(pred_gidx), e_gi);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    int pcs[8];
    for (int i = 0; i < 1024; i++) begin m_lh[i] = 0; m_lc[i] = 3; end
    for (int i = 0; i < 4096; i++) begin m_gc[i] = 1; m_ch[i] = 1; end
    m_ghr = 0;
    // pcs 4..7 share local rows with 0..3 (differ above bit 11)
    for (int k = 0; k < 8; k++) pcs[k] = 32'h100 + (k % 4) * 12 + (k / 4) * 4096;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: no result right after reset
    chk("R1 pred_valid after reset", int'(pred_valid), 0);
    // R1: first prediction not taken, indices zero (model holds reset values)
    cyc(1, pcs[0], 0, 0, 0, 0, 0);
    chk("R1 first taken", int'(pred_taken), 0);
    chk("R1 first lidx", int'(pred_lidx), 0);
    chk("R1 first gidx", int'(pred_gidx), 0);

    for (int it = 0; it < 3000; it++) begin
      int  k, lag, upc, uli, ugi;
      bit  pv, uv, ut, outc;
      k   = (it * 3 + it / 7) % 8;
      pv  = ((it % 11) != 5);   // R2 idle cycles
      lag = ((it / 50) % 3 == 1) ? 2 : 0;  // R8 delayed training
      uv = 0; upc = 0; ut = 0; uli = 0; ugi = 0;
      if (q_pc.size() > lag) begin
        uv = 1; upc = q_pc.pop_front(); uli = q_li.pop_front();
        ugi = q_gi.pop_front(); ut = q_out.pop_front();
      end
      cyc(pv, pcs[k], uv, upc, ut, uli, ugi);
      if (pv) begin
        // outcome patterns: biased loops per branch, long runs for saturation (R5 R6)
        case (k)
          0: outc = 1'b1;
          1: outc = 1'b0;
          2: outc = ((it % 4) != 0);
          3: outc = ((it / 200) % 2 == 0);
          4: outc = ((it % 3) == 0);
          5: outc = ((it / 9) % 2 == 1);
          6: outc = ((it % 5) != 2);
          default: outc = ((it % 2) == 0);
        endcase
        q_pc.push_back(pcs[k]); q_li.push_back(e_li);
        q_gi.push_back(e_gi);   q_out.push_back(int'(outc));
      end
    end
    // drain, then check idle output (R2)
    while (q_pc.size() > 0)
      cyc(0, 0, 1, q_pc.pop_front(), q_out.pop_front() != 0,
          q_li.pop_front(), q_gi.pop_front());
    cyc(0, 0, 0, 0, 0, 0, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule